// File: doc/BRIEF.md
# Compressed Register-Form ALU Decoder

This block decodes a 16-bit compressed parcel that belongs to the register-to-register arithmetic, logical or system group. A mode input selects between the narrow form and the full form. In the narrow form the upper five parcel bits hold the entry opcode and carry no meaning here. In the full form all sixteen bits are in use. The decode is purely combinational. It produces an operation select, the three register numbers, a flag that marks a zero source operand, and a condition-register target with its write enable. An illegal flag covers opcodes that the current mode does not offer and slots that are still unassigned.

The destination register is not always encoded. In the narrow form it is implied and equals the second source. A zero in the first-source field does not select a register. It either supplies a literal zero or turns the instruction into a different, unary operation. The same opcode decodes as a move in the narrow form and as a not-or in the full form. The only stored state is the encoding-bank register, which a bank-select instruction writes.

Parcel field layout, with bit 15 as the most significant bit: bit 15 is the wide prefix bit. Bit 14 is the alternate-form bit. Bits 13:11 hold the wide destination field (D). Bits 10:8 hold the major opcode. Bit 7 holds the minor opcode. Bits 6:4 hold source field B. Bits 3:1 hold source field A. Bit 0 is the continuation bit, which this block ignores. In this document, "group g" means the 4-bit value {bits 10:8, bit 7}.

Top module: `cparcel_alu_dec`

## Requirements
- R1: Outputs `ra` and `rb` always equal parcel bits 3:1 and 6:4. Output `rt` equals bits 6:4 when `mode16`=0, and bits 13:11 when `mode16`=1. When `mode16`=0, parcel bits 15:11 have no effect on any output.
- R2: The shared arithmetic forms apply when `mode16`=0 or bit 14=0. Group 4'b0100 with A nonzero gives `op`=1 (add). Group 4'b0101 gives `op`=2 (subtract, record). Group 4'b0110 gives `op`=3 (unsigned compare).
- R3: For subtract, unsigned compare and signed compare, `ra_zero`=1 exactly when A is zero. All other decodes drive `ra_zero`=0.
- R4: Subtract and the shift forms write CR field 0 (`cr_we`=1, `cr_field`=0). The compares write field 0 when `mode16`=0 and field D when `mode16`=1. All other decodes drive `cr_we`=0.
- R5: The shared logical forms with A nonzero apply when `mode16`=0 or bit 14=0. Group 4'b1000 gives and (8). Group 4'b1001 gives nand (9). Group 4'b1010 gives or (10). Group 4'b1011 gives nor (11) when `mode16`=1 and move (12) when `mode16`=0.
- R6: With A zero and bit 14 clear, the logical groups give the unary forms. Group 1000 gives sign-extend word (16). Group 1001 gives count leading zeros (19). Group 1010 gives population count (21). Group 1011 gives not (15). When `mode16`=0, only not is legal; the other three raise `illegal`.
- R7: When `mode16`=1 and bit 14=1, the groups decode as follows. Group 0100 gives shift left (5). Group 0101 gives shift right (6) when A is nonzero and shift right algebraic (7) when A is zero. Group 0110 gives signed compare (4). Group 1010 with A nonzero gives xor (13). Group 1011 gives eqv (14) when A is nonzero and sign-extend halfword (18) when A is zero. Group 1000 with A zero gives sign-extend byte (17). Group 1001 with A zero gives count trailing zeros (20).
- R8: Unassigned full-form slots raise `illegal`. These are bit 14=1 with A nonzero in groups 1000 and 1001, and bit 14=1 with A zero in group 1010. Whenever `illegal`=1, the outputs are `op`=0, `cr_we`=0 and `bank_wr`=0.
- R9: Group 0100 with A zero and bit 14=0 is bank select (22), and it is legal only when `mode16`=1. When `mode16`=0 it raises `illegal`. `bank_wr` is 1 only for a legal bank select with `valid`=1.
- R10: `bank` resets to 0. On the clock edge that follows a cycle with `bank_wr`=1, `bank` takes the value of field B from that cycle. At every other edge it holds its value. While `bank_wr` is high, `bank` still shows the old value.
- R11: A parcel whose group lies outside {0100, 0101, 0110, 1000, 1001, 1010, 1011} gives `op`=0, `illegal`=0, `cr_we`=0 and `ra_zero`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank register |
| rst_n | input | 1 | Active-low reset |
| valid | input | 1 | Parcel is a real instruction this cycle |
| mode16 | input | 1 | 1 = full 16-bit form, 0 = narrow form |
| parcel | input | 16 | Instruction parcel |
| op | output | 5 | Operation select, 0 = none |
| rt | output | 3 | Destination register number |
| ra | output | 3 | First source field |
| rb | output | 3 | Second source field |
| ra_zero | output | 1 | First source is a literal zero |
| cr_we | output | 1 | Condition-register field write |
| cr_field | output | 3 | Condition-register field written |
| illegal | output | 1 | Opcode unavailable or unassigned |
| bank_wr | output | 1 | Bank register loads this cycle |
| bank | output | 3 | Current encoding bank |

## Verification
Two functions can meet in one cycle: a new bank-select decode raises `bank_wr`, and the bank register still shows the result of the previous bank select. The bench provokes this by issuing two bank selects with different values on consecutive cycles. In the second cycle it expects `bank_wr` high and `bank` holding the first value, and on the following cycle it expects the second value. The decode is covered by a full sweep of every parcel in both modes, checked against an arithmetic model. Illegal, narrow-form and invalid bank selects are then shown to leave `bank` unchanged.

// File: rtl/cparcel_pkg.sv
package cparcel_pkg;

   localparam int PARCEL_W = 16;
   localparam int FIELD_W  = 3;
   localparam int OP_W     = 5;

   typedef enum logic [OP_W-1:0] {
      OP_NONE   = 5'd0,
      OP_ADD    = 5'd1,
      OP_SUB    = 5'd2,
      OP_CMPL   = 5'd3,
      OP_CMPW   = 5'd4,
      OP_SLD    = 5'd5,
      OP_SRD    = 5'd6,
      OP_SRAD   = 5'd7,
      OP_AND    = 5'd8,
      OP_NAND   = 5'd9,
      OP_OR     = 5'd10,
      OP_NOR    = 5'd11,
      OP_MR     = 5'd12,
      OP_XOR    = 5'd13,
      OP_EQV    = 5'd14,
      OP_NOT    = 5'd15,
      OP_EXTSW  = 5'd16,
      OP_EXTSB  = 5'd17,
      OP_EXTSH  = 5'd18,
      OP_CNTLZ  = 5'd19,
      OP_CNTTZ  = 5'd20,
      OP_POPCNT = 5'd21,
      OP_CBANK  = 5'd22
   } alu_op_e;

   // parcel split, most significant field first
   typedef struct packed {
      logic               wide;   // bit 15
      logic               alt;    // bit 14, alternate full-form encoding
      logic [FIELD_W-1:0] fd;     // bits 13:11
      logic [3:0]         grp;    // bits 10:7, major and minor
      logic [FIELD_W-1:0] fb;     // bits 6:4
      logic [FIELD_W-1:0] fa;     // bits 3:1
      logic               cont;   // bit 0
   } parcel_t;

   localparam logic [3:0] GRP_ADD = 4'b0100;
   localparam logic [3:0] GRP_SUB = 4'b0101;
   localparam logic [3:0] GRP_CMP = 4'b0110;
   localparam logic [3:0] GRP_AND = 4'b1000;
   localparam logic [3:0] GRP_NND = 4'b1001;
   localparam logic [3:0] GRP_OR  = 4'b1010;
   localparam logic [3:0] GRP_NOR = 4'b1011;

endpackage

// File: rtl/cparcel_split.sv
module cparcel_split
   import cparcel_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] parcel,
   input  logic         mode16,
   output parcel_t      f,
   output logic         ra_nil,
   output logic         alt_on
);
   generate
      if (W != $bits(parcel_t)) begin : g_bad_width
         $error("cparcel_split: parcel width must match the field layout");
      end
   endgenerate

   assign f      = parcel_t'(parcel);
   assign ra_nil = (f.fa == '0);
   assign alt_on = mode16 & f.alt;
endmodule

// File: rtl/cparcel_core.sv
module cparcel_core
   import cparcel_pkg::*;
(
   input  parcel_t            f,
   input  logic               mode16,
   input  logic               ra_nil,
   input  logic               alt_on,
   output alu_op_e            op,
   output logic               illegal,
   output logic               ra_zero,
   output logic               cr_we,
   output logic [FIELD_W-1:0] cr_field,
   output logic [FIELD_W-1:0] rt
);
   alu_op_e sel;
   logic    bad;

   always_comb begin
      sel = OP_NONE;
      bad = 1'b0;
      unique case (f.grp)
         GRP_ADD: begin
            if (alt_on)      sel = OP_SLD;
            else if (!ra_nil) sel = OP_ADD;
            else if (mode16) sel = OP_CBANK;
            else             bad = 1'b1;
         end
         GRP_SUB: begin
            if (alt_on) sel = ra_nil ? OP_SRAD : OP_SRD;
            else        sel = OP_SUB;
         end
         GRP_CMP: sel = alt_on ? OP_CMPW : OP_CMPL;
         GRP_AND: begin
            if (alt_on) begin
               if (ra_nil) sel = OP_EXTSB;
               else        bad = 1'b1;
            end else if (!ra_nil) sel = OP_AND;
            else if (mode16)      sel = OP_EXTSW;
            else                  bad = 1'b1;
         end
         GRP_NND: begin
            if (alt_on) begin
               if (ra_nil) sel = OP_CNTTZ;
               else        bad = 1'b1;
            end else if (!ra_nil) sel = OP_NAND;
            else if (mode16)      sel = OP_CNTLZ;
            else                  bad = 1'b1;
         end
         GRP_OR: begin
            if (alt_on) begin
               if (ra_nil) bad = 1'b1;
               else        sel = OP_XOR;
            end else if (!ra_nil) sel = OP_OR;
            else if (mode16)      sel = OP_POPCNT;
            else                  bad = 1'b1;
         end
         GRP_NOR: begin
            if (alt_on)      sel = ra_nil ? OP_EXTSH : OP_EQV;
            else if (ra_nil) sel = OP_NOT;
            else             sel = mode16 ? OP_NOR : OP_MR;
         end
         default: sel = OP_NONE;
      endcase
   end

   always_comb begin
      ra_zero  = 1'b0;
      cr_we    = 1'b0;
      cr_field = '0;
      unique case (sel)
         OP_SUB: begin
            ra_zero = ra_nil;
            cr_we   = 1'b1;
         end
         OP_CMPL, OP_CMPW: begin
            ra_zero  = ra_nil;
            cr_we    = 1'b1;
            cr_field = mode16 ? f.fd : '0;
         end
         OP_SLD, OP_SRD, OP_SRAD: cr_we = 1'b1;
         default: cr_we = 1'b0;
      endcase
   end

   assign op      = sel;
   assign illegal = bad;
   assign rt      = mode16 ? f.fd : f.fb;
endmodule

// File: rtl/cparcel_bank.sv
module cparcel_bank #(
   parameter int W         = 3,
   parameter int INIT      = 0,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] RESET_VAL = W'(INIT);

   generate
      if (INIT < 0 || INIT >= (1 << W)) begin : g_bad_init
         $error("cparcel_bank: INIT does not fit in W bits");
      end
      if (ASYNC_RST) begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q <= RESET_VAL;
            else if (load) q <= d;
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n)    q <= RESET_VAL;
            else if (load) q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/cparcel_alu_dec.sv
module cparcel_alu_dec
   import cparcel_pkg::*;
#(
   parameter int PARCEL_W  = 16,
   parameter int REG_W     = 3,
   parameter int BANK_W    = 3,
   parameter int BANK_INIT = 0,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                valid,
   input  logic                mode16,
   input  logic [PARCEL_W-1:0] parcel,
   output logic [OP_W-1:0]     op,
   output logic [REG_W-1:0]    rt,
   output logic [REG_W-1:0]    ra,
   output logic [REG_W-1:0]    rb,
   output logic                ra_zero,
   output logic                cr_we,
   output logic [REG_W-1:0]    cr_field,
   output logic                illegal,
   output logic                bank_wr,
   output logic [BANK_W-1:0]   bank
);
   generate
      if (PARCEL_W != cparcel_pkg::PARCEL_W || REG_W != FIELD_W || BANK_W != FIELD_W) begin : g_bad_cfg
         $error("cparcel_alu_dec: widths are fixed by the parcel layout");
      end
   endgenerate

   parcel_t f;
   logic    ra_nil;
   logic    alt_on;
   alu_op_e sel;

   cparcel_split #(.W(PARCEL_W)) u_split (
      .parcel (parcel),
      .mode16 (mode16),
      .f      (f),
      .ra_nil (ra_nil),
      .alt_on (alt_on)
   );

   cparcel_core u_core (
      .f        (f),
      .mode16   (mode16),
      .ra_nil   (ra_nil),
      .alt_on   (alt_on),
      .op       (sel),
      .illegal  (illegal),
      .ra_zero  (ra_zero),
      .cr_we    (cr_we),
      .cr_field (cr_field),
      .rt       (rt)
   );

   assign op      = sel;
   assign ra      = f.fa;
   assign rb      = f.fb;
   assign bank_wr = valid & (sel == OP_CBANK);

   cparcel_bank #(.W(BANK_W), .INIT(BANK_INIT), .ASYNC_RST(ASYNC_RST)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (bank_wr),
      .d     (f.fb),
      .q     (bank)
   );
endmodule

// File: rtl/cparcel_alu_dec_chk.sv
module cparcel_alu_dec_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       valid,
   input logic       mode16,
   input logic [4:0] op,
   input logic [2:0] rt,
   input logic [2:0] ra,
   input logic [2:0] rb,
   input logic       ra_zero,
   input logic       cr_we,
   input logic [2:0] cr_field,
   input logic       illegal,
   input logic       bank_wr,
   input logic [2:0] bank
);
   // R1: narrow form takes its destination from field B
   p_narrow_dest_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !mode16 |-> rt == rb);

   // R3: zero-operand flag only with a zero A field on sub or compare
   p_zero_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ra_zero |-> (ra == 3'd0 && (op == 5'd2 || op == 5'd3 || op == 5'd4)));

   // R4: subtract and shifts target field 0
   p_cr0_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cr_we && (op == 5'd2 || op == 5'd5 || op == 5'd6 || op == 5'd7)) |-> cr_field == 3'd0);

   // R8: an illegal decode produces no side effect
   p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (op == 5'd0 && !cr_we && !bank_wr));

   // R9: bank writes only in full form with a valid parcel
   p_bank_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bank_wr |-> (mode16 && valid));

   // R10: bank loads field B after a write
   p_bank_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bank_wr |=> bank == $past(rb));

   // R10: bank holds without a write
   p_bank_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_wr |=> $stable(bank));
endmodule

bind cparcel_alu_dec cparcel_alu_dec_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .valid    (valid),
   .mode16   (mode16),
   .op       (op),
   .rt       (rt),
   .ra       (ra),
   .rb       (rb),
   .ra_zero  (ra_zero),
   .cr_we    (cr_we),
   .cr_field (cr_field),
   .illegal  (illegal),
   .bank_wr  (bank_wr),
   .bank     (bank)
);

// File: tb/cparcel_alu_dec_test.sv
module cparcel_alu_dec_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid = 1'b0;
   logic        mode16 = 1'b0;
   logic [15:0] parcel = '0;
   logic [4:0]  op;
   logic [2:0]  rt, ra, rb, cr_field, bank;
   logic        ra_zero, cr_we, illegal, bank_wr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 20-unit period, 50 MHz

   cparcel_alu_dec uut (
      .clk(clk), .rst_n(rst_n), .valid(valid), .mode16(mode16), .parcel(parcel),
      .op(op), .rt(rt), .ra(ra), .rb(rb), .ra_zero(ra_zero), .cr_we(cr_we),
      .cr_field(cr_field), .illegal(illegal), .bank_wr(bank_wr), .bank(bank)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d (mode16=%0d parcel=%h)",
                  tag, what, act, exp, mode16, parcel);
      end
   endtask

   // arithmetic model of the requirements
   task automatic model(input bit m16, input logic [15:0] p,
                        output int eop, output int eill, output int ez,
                        output int ecw, output int ecf, output int ert, output string tag);
      int  g   = int'(p[10:7]);
      bit  alt = m16 && p[14];
      bit  z   = (p[3:1] == 3'd0);
      eop = 0; eill = 0; ez = 0; ecw = 0; ecf = 0;
      ert = m16 ? int'(p[13:11]) : int'(p[6:4]);
      tag = "R11";
      if (g == 4 || g == 5 || g == 6) tag = alt ? "R7" : "R2";
      if (g >= 8 && g <= 11)          tag = alt ? "R7" : (z ? "R6" : "R5");
      case (g)
         4:  if (alt) eop = 5; else if (!z) eop = 1;
             else begin tag = "R9"; if (m16) eop = 22; else eill = 1; end
         5:  if (alt) eop = z ? 7 : 6; else begin eop = 2; ez = z; end
         6:  begin eop = alt ? 4 : 3; ez = z; end
         8:  if (alt) begin if (z) eop = 17; else eill = 1; end
             else if (!z) eop = 8; else if (m16) eop = 16; else eill = 1;
         9:  if (alt) begin if (z) eop = 20; else eill = 1; end
             else if (!z) eop = 9; else if (m16) eop = 19; else eill = 1;
         10: if (alt) begin if (z) eill = 1; else eop = 13; end
             else if (!z) eop = 10; else if (m16) eop = 21; else eill = 1;
         11: if (alt) eop = z ? 18 : 14; else if (z) eop = 15; else eop = m16 ? 11 : 12;
         default: ;
      endcase
      if (alt && eill == 1) tag = "R8";
      if (eop == 2 || (eop >= 5 && eop <= 7)) ecw = 1;
      if (eop == 3 || eop == 4) begin ecw = 1; ecf = m16 ? int'(p[13:11]) : 0; end
   endtask

   function automatic logic [15:0] mk(input int d, input int g, input int b, input int a, input int alt);
      return {1'b0, alt[0], d[2:0], g[3:0], b[2:0], a[2:0], 1'b0};
   endfunction

   initial begin
      int eop, eill, ez, ecw, ecf, ert;
      string tag;

      // reset state
      repeat (3) @(negedge clk);
      check("R10", "bank at reset", int'(bank), 0);
      check("R9", "bank_wr at reset", int'(bank_wr), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // full sweep of both modes with valid low
      for (int m = 0; m < 2; m++) begin
         for (int p = 0; p < 65536; p++) begin
            #1;
            mode16 = m[0];
            parcel = p[15:0];
            #2;
            model(m[0], p[15:0], eop, eill, ez, ecw, ecf, ert, tag);
            check(tag, "op", int'(op), eop);
            check(eill ? tag : "R8", "illegal", int'(illegal), eill);
            check("R1", "rt", int'(rt), ert);
            check("R1", "ra", int'(ra), int'(p[3:1]));
            check("R1", "rb", int'(rb), int'(p[6:4]));
            check("R3", "ra_zero", int'(ra_zero), ez);
            check("R4", "cr_we", int'(cr_we), ecw);
            if (ecw != 0) check("R4", "cr_field", int'(cr_field), ecf);
            check("R10", "bank_wr with valid low", int'(bank_wr), 0);
            #2;
         end
      end
      check("R10", "bank after sweep", int'(bank), 0);

      // back-to-back bank selects
      @(negedge clk);
      valid = 1'b1; mode16 = 1'b1; parcel = mk(3, 4, 5, 0, 0);
      #2;
      check("R9", "bank_wr first select", int'(bank_wr), 1);
      check("R10", "old bank visible", int'(bank), 0);
      @(negedge clk);
      parcel = mk(0, 4, 3, 0, 0);
      #2;
      check("R9", "bank_wr second select", int'(bank_wr), 1);
      check("R10", "bank after first select", int'(bank), 5);
      @(negedge clk);
      valid = 1'b0;
      #2;
      check("R10", "bank after second select", int'(bank), 3);

      // narrow-form bank select is illegal and leaves bank alone
      @(negedge clk);
      valid = 1'b1; mode16 = 1'b0; parcel = mk(0, 4, 6, 0, 0);
      #2;
      check("R9", "narrow select illegal", int'(illegal), 1);
      check("R9", "narrow select no write", int'(bank_wr), 0);
      @(negedge clk);
      // alternate bit set: shift, not a bank select
      mode16 = 1'b1; parcel = mk(0, 4, 7, 0, 1);
      #2;
      check("R7", "alt group 0100 is shift", int'(op), 5);
      check("R9", "shift no bank write", int'(bank_wr), 0);
      @(negedge clk);
      // valid low bank select
      valid = 1'b0; parcel = mk(0, 4, 6, 0, 0);
      #2;
      check("R10", "no write without valid", int'(bank_wr), 0);
      @(negedge clk);
      #2;
      check("R10", "bank held", int'(bank), 3);

      // reset clears bank
      rst_n = 1'b0;
      @(negedge clk);
      #2;
      check("R10", "bank cleared by reset", int'(bank), 0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule